// File: doc/BRIEF.md
# Medium Activity Cycle Counters

This block keeps four 32-bit counters that measure how the radio medium is used, all ticking at the core clock. One counts every clock cycle, one counts cycles while the receiver reports the channel busy, one counts cycles spent receiving frames and one counts cycles spent sending frames. A host turns these counts into listen time as (total − receive-frame − transmit-frame) divided by the clock rate. The counters therefore have to advance once per core clock.

A single freeze bit in a control register halts all four counters on the same edge. The host can then read a consistent snapshot of the four values, zero each counter with a write, and clear the freeze to resume. Each counter stops at all-ones instead of wrapping, and it raises a sticky overflow flag in the control register.

The register port is a plain single-cycle write strobe with address and data. It has a combinational read path that always shows the register at the current address.

Top module: `chan_activity_counters`

## Requirements
- R1: After reset all four counters read 0, and the control register reads 0, so freeze is clear and every overflow flag is clear.
- R2: The total counter (address 1) grows by one on every clock edge where the counters are not frozen and the counter is not written.
- R3: The busy counter (address 2), receive-frame counter (address 3) and transmit-frame counter (address 4) grow by one on an unfrozen edge only while rx_busy_i, rx_frame_i or tx_frame_i, respectively, is high.
- R4: A write to the control register (address 0) with bit 0 set stops all four counters from that same edge on. While frozen, no counter changes even when the activity inputs are high, and repeated reads return the same value.
- R5: A write to the control register with bit 0 clear lets the counters count again, starting on the edge of that write.
- R6: A write to a counter address loads the written value, so writing 0 clears the counter. The write takes priority over an increment on the same edge, and it is accepted while frozen.
- R7: A counter at 0xFFFFFFFF stays there when it would otherwise increment.
- R8: Control register bits 4 to 7 are sticky overflow flags for the counters at addresses 1 to 4. A flag sets when its counter tries to increment past 0xFFFFFFFF. Writing 1 to a flag bit in the control register clears that flag, and writing 0 leaves it unchanged.
- R9: Addresses 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; all counters advance on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_busy_i | input | 1 | Receive channel busy level |
| rx_frame_i | input | 1 | Frame reception in progress level |
| tx_frame_i | input | 1 | Frame transmission in progress level |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register address for both read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |

## Verification
The hardest condition to reach is saturation together with the overflow flag, because counting up to 0xFFFFFFFF from reset would take billions of cycles. The stimulus loads values a few counts below all-ones into the counters through the normal write path and then lets the counters run into the ceiling. It also clears one flag with a write-one while the other flags stay set. The same-edge behaviour of freeze and of a load that collides with an increment is reached by writing while the activity inputs are held high.

// File: rtl/chan_act_pkg.sv
package chan_act_pkg;
    localparam int CNT_W   = 32;
    localparam int NUM_CNT = 4;
    localparam int ADDR_W  = 3;
    // control register layout
    localparam int FRZ_BIT = 0;
    localparam int OVF_LSB = 4;
    // counter order: index i lives at address i+1
    typedef enum logic [1:0] {
        CNT_TOTAL  = 2'd0,
        CNT_BUSY   = 2'd1,
        CNT_RXFRM  = 2'd2,
        CNT_TXFRM  = 2'd3
    } cnt_idx_e;
endpackage

// File: rtl/cc_act_counter.sv
module cc_act_counter #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         frz_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         ovf_clr_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] MAX_V = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = st_q.ovf & ~ovf_clr_i;
        if (ld_i) begin
            st_d.cnt = ld_val_i;
        end else if (inc_i && !frz_i) begin
            if (st_q.cnt == MAX_V) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;
endmodule

// File: rtl/cc_ctrl_regs.sv
module cc_ctrl_regs #(
    parameter int W      = 32,
    parameter int N      = 4,
    parameter int AW     = 3,
    parameter int FRZ_B  = 0,
    parameter int OVF_B  = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [W-1:0]        wdata_i,
    input  logic [N-1:0][W-1:0] cnt_i,
    input  logic [N-1:0]        ovf_i,
    output logic                frz_eff_o,
    output logic                frz_q_o,
    output logic [N-1:0]        ld_o,
    output logic [N-1:0]        ovf_clr_o,
    output logic [W-1:0]        rdata_o
);
    localparam logic [AW-1:0] CTRL_ADR = '0;

    typedef struct packed {
        logic frz;
    } st_t;

    st_t  st_d, st_q;
    logic ctrl_wr;

    always_comb begin
        ctrl_wr   = wr_i && (addr_i == CTRL_ADR);
        st_d      = st_q;
        if (ctrl_wr) begin
            st_d.frz = wdata_i[FRZ_B];
        end
        frz_eff_o = st_d.frz;
        ovf_clr_o = ctrl_wr ? wdata_i[OVF_B +: N] : '0;
    end

    for (genvar g = 0; g < N; g++) begin : g_dec
        assign ld_o[g] = wr_i && (addr_i == AW'(g + 1));
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_ADR) begin
            rdata_o[FRZ_B]       = st_q.frz;
            rdata_o[OVF_B +: N]  = ovf_i;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (addr_i == AW'(i + 1)) begin
                    rdata_o = cnt_i[i];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frz_q_o = st_q.frz;
endmodule

// File: rtl/chan_activity_counters.sv
module chan_activity_counters
    import chan_act_pkg::*;
#(
    parameter int DATA_W = CNT_W,
    parameter int A_W    = ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_busy_i,
    input  logic              rx_frame_i,
    input  logic              tx_frame_i,
    input  logic              reg_wr_i,
    input  logic [A_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o
);
    logic [NUM_CNT-1:0][DATA_W-1:0] cnt_w;
    logic [NUM_CNT-1:0]             ovf_w;
    logic [NUM_CNT-1:0]             ld_w;
    logic [NUM_CNT-1:0]             ovf_clr_w;
    logic [NUM_CNT-1:0]             act_w;
    logic                           frz_eff_w;
    logic                           frz_q_w;

    always_comb begin
        act_w            = '0;
        act_w[CNT_TOTAL] = 1'b1;
        act_w[CNT_BUSY]  = rx_busy_i;
        act_w[CNT_RXFRM] = rx_frame_i;
        act_w[CNT_TXFRM] = tx_frame_i;
    end

    cc_ctrl_regs #(
        .W(DATA_W), .N(NUM_CNT), .AW(A_W), .FRZ_B(FRZ_BIT), .OVF_B(OVF_LSB)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .cnt_i     (cnt_w),
        .ovf_i     (ovf_w),
        .frz_eff_o (frz_eff_w),
        .frz_q_o   (frz_q_w),
        .ld_o      (ld_w),
        .ovf_clr_o (ovf_clr_w),
        .rdata_o   (reg_rdata_o)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        cc_act_counter #(.W(DATA_W)) u_cnt (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .inc_i     (act_w[g]),
            .frz_i     (frz_eff_w),
            .ld_i      (ld_w[g]),
            .ld_val_i  (reg_wdata_i),
            .ovf_clr_i (ovf_clr_w[g]),
            .cnt_o     (cnt_w[g]),
            .ovf_o     (ovf_w[g])
        );
    end
endmodule

// File: rtl/chan_activity_counters_chk.sv
module chan_activity_counters_chk #(
    parameter int W  = 32,
    parameter int N  = 4,
    parameter int AW = 3
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                rx_busy_i,
    input logic                reg_wr_i,
    input logic [AW-1:0]       reg_addr_i,
    input logic [W-1:0]        reg_wdata_i,
    input logic [N-1:0][W-1:0] cnt,
    input logic [N-1:0]        ovf,
    input logic                frz_q
);
    localparam logic [W-1:0] MAXV = '1;
    logic any_wr;
    assign any_wr = reg_wr_i;

    // R4: frozen and no write -> nothing moves
    assert_frozen_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frz_q && !any_wr) |=> (cnt == $past(cnt)));

    // R2: running, no write -> total steps by one unless saturated
    assert_total_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!frz_q && !any_wr && cnt[0] != MAXV) |=> (cnt[0] == $past(cnt[0]) + 1'b1));

    // R3: busy counter holds while busy input low
    assert_busy_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rx_busy_i && !any_wr) |=> $stable(cnt[1]));

    // R6: load lands on the next edge
    assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == AW'(1)) |=> (cnt[0] == $past(reg_wdata_i)));

    // R7: saturated total stays saturated
    assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt[0] == MAXV && !any_wr) |=> (cnt[0] == MAXV));

    // R8: flag stays set unless a clearing write arrives
    assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf[0] && !(reg_wr_i && reg_addr_i == '0 && reg_wdata_i[4])) |=> ovf[0]);
endmodule

bind chan_activity_counters chan_activity_counters_chk #(
    .W(DATA_W), .N(chan_act_pkg::NUM_CNT), .AW(A_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_busy_i   (rx_busy_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .cnt         (cnt_w),
    .ovf         (ovf_w),
    .frz_q       (frz_q_w)
);

// File: tb/chan_activity_counters_bench.sv
module chan_activity_counters_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_busy = 1'b0, rx_frame = 1'b0, tx_frame = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    logic [31:0] m_cnt [4] = '{default: 32'd0};
    bit          m_ovf [4] = '{default: 1'b0};
    bit          m_frz = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    chan_activity_counters u_chan_activity_counters (
        .clk_i(clk), .rst_ni(rst_n), .rx_busy_i(rx_busy), .rx_frame_i(rx_frame),
        .tx_frame_i(tx_frame), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata));

    function automatic logic [31:0] model_read(input logic [2:0] a);
        logic [31:0] v = 32'd0;
        if (a == 3'd0) begin
            v[0] = m_frz;
            for (int i = 0; i < 4; i++) v[4+i] = m_ovf[i];
        end else if (a <= 3'd4) begin
            v = m_cnt[a-1];
        end
        return v;
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R8";
            3'd1: return "R2";
            3'd2, 3'd3, 3'd4: return "R3";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%0d got=%h expected=%h at %0t", tag, addr, got, exp, $time);
        end
    endtask

    // reference model update on every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_ovf[i] = 0; end
            m_frz = 0;
        end else begin
            bit f = m_frz;
            bit act [4];
            act[0] = 1; act[1] = rx_busy; act[2] = rx_frame; act[3] = tx_frame;
            if (wr && addr == 3'd0) begin
                f = wdata[0];
                for (int i = 0; i < 4; i++) if (wdata[4+i]) m_ovf[i] = 0;
            end
            for (int i = 0; i < 4; i++) begin
                if (wr && addr == 3'(i+1)) m_cnt[i] = wdata;
                else if (act[i] && !f) begin
                    if (m_cnt[i] == 32'hFFFF_FFFF) m_ovf[i] = 1;
                    else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            m_frz = f;
        end
    end

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        check(rst_n ? tag_of(addr) : "R1", rdata, model_read(addr));
    end

    task automatic step(); @(posedge clk); #2; endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        wr = 1; addr = a; wdata = d; step(); wr = 0;
    endtask

    task automatic read_check(input string tag, input logic [2:0] a);
        addr = a; @(negedge clk); check(tag, rdata, model_read(a)); step();
    endtask

    initial begin : watchdog
        #3_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        // R1: reset state
        for (int a = 0; a < 5; a++) begin addr = 3'(a); @(negedge clk); check("R1", rdata, 32'd0); end
        @(posedge clk); #2; rst_n = 1;
        for (int a = 0; a < 5; a++) read_check("R1", 3'(a));

        // R2 R3: mixed activity patterns
        for (int c = 0; c < 300; c++) begin
            rx_busy  = c[0] | c[3];
            rx_frame = (c % 5) == 1;
            tx_frame = (c % 7) > 3;
            addr = 3'(c % 8);
            step();
        end
        read_check("R3", 3'd2); read_check("R3", 3'd3); read_check("R3", 3'd4);

        // R4: freeze with all inputs high
        rx_busy = 1; rx_frame = 1; tx_frame = 1;
        reg_write(3'd0, 32'h1);
        addr = 3'd1; @(negedge clk); snap = rdata;
        for (int c = 0; c < 20; c++) begin step(); addr = 3'(1 + c % 4); end
        addr = 3'd1; @(negedge clk); check("R4", rdata, snap);
        read_check("R4", 3'd0);

        // R6: clear each counter while frozen
        for (int i = 1; i <= 4; i++) reg_write(3'(i), 32'd0);
        for (int i = 1; i <= 4; i++) read_check("R6", 3'(i));

        // R5: unfreeze resumes on that edge
        reg_write(3'd0, 32'h0);
        read_check("R5", 3'd1); read_check("R5", 3'd4);

        // R6: load beats increment
        reg_write(3'd2, 32'd5);
        read_check("R6", 3'd2);

        // R9: unmapped writes ignored, reads zero
        reg_write(3'd6, 32'hFFFF_FFFF);
        reg_write(3'd5, 32'h1);
        read_check("R9", 3'd7);
        read_check("R9", 3'd0);
        read_check("R9", 3'd1);

        // R7 R8: run into the ceiling
        for (int i = 1; i <= 4; i++) reg_write(3'(i), 32'hFFFF_FFFC);
        for (int c = 0; c < 12; c++) step();
        for (int i = 1; i <= 4; i++) read_check("R7", 3'(i));
        read_check("R8", 3'd0);
        // clear flag of total counter only; bit 0 stays clear
        reg_write(3'd1, 32'd0);
        reg_write(3'd0, 32'h10);
        read_check("R8", 3'd0);
        reg_write(3'd0, 32'h0);
        read_check("R8", 3'd0);

        for (int c = 0; c < 10; c++) step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule